// File: doc/BRIEF.md
# Element-Width Saturating Integer Adder

This block is a combinational integer adder on a 64-bit datapath whose operation width is chosen per operation: the low 8, 16, 32 or all 64 bits of each operand take part, and everything above the chosen lane is discarded. The operation is always an add. The carry-in either joins the sum or is ignored. The carry-out is taken one bit above the lane. An overflow flag is raised when the exact sum does not fit the range in use. An optional clamping stage then saturates the result, either to the signed range or to the unsigned range.

The saturation stage treats the sum as exact. The operands are sign- or zero-extended and added with two spare bits, and that value is then compared against the bounds of the lane. Unsigned clamping of a negative exact sum therefore gives zero. A 4-bit condition field summarises the final result against zero. Its overflow bit reflects only the current operation and never accumulates across operations. A build parameter adds one output register stage. With that stage, all outputs appear one clock after their inputs.

Top module: `ew_sat_adder`

## Requirements
- R1: `ew_sel` codes 0, 1, 2 and 3 select lane widths of 8, 16, 32 and 64 bits. With `sat_sel` = 0, `result` is the low lane bits of a + b (+ carry), wrapped, and every result bit above the lane is 0.
- R2: Operand bits above the selected lane have no effect on any output.
- R3: `carry_in` enters the sum only when `use_carry` = 1; otherwise it is ignored.
- R4: `carry_out` is bit w of the unsigned sum of the zero-extended w-bit operands plus the effective carry, where w is the lane width.
- R5: The target range is signed when `sat_sel` = 1, and unsigned when `sat_sel` = 2. For `sat_sel` 0 or 3, `op_signed` chooses the range. `overflow` is 1 exactly when the exact sum lies outside the target range. The exact sum uses operands sign-extended when `op_signed` = 1 and zero-extended otherwise.
- R6: With `sat_sel` = 1, an exact sum above 2^(w-1)-1 yields 2^(w-1)-1. An exact sum below -2^(w-1) yields -2^(w-1), written as w-bit two's complement.
- R7: With `sat_sel` = 2, an exact sum above 2^w-1 yields 2^w-1. A negative exact sum, possible only when `op_signed` = 1, yields 0.
- R8: When `rec_en` = 1, `cond[3]` (LT), `cond[2]` (GT) and `cond[1]` (EQ) compare the final result, read as a signed w-bit value, with zero. Exactly one of the three is set.
- R9: When `rec_en` = 1, `cond[0]` (SO) equals `overflow` of the same operation, with no memory of earlier ones. When `rec_en` = 0, `cond` is 0.
- R10: With `REG_OUT` = 1, all outputs reflect the inputs present at the preceding rising clock edge, and they are 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_a | input | 64 | First addend |
| op_b | input | 64 | Second addend |
| carry_in | input | 1 | Carry input bit |
| use_carry | input | 1 | 1 selects add-with-carry |
| ew_sel | input | 2 | Lane width code (0:8, 1:16, 2:32, 3:64) |
| op_signed | input | 1 | Operands are two's complement |
| sat_sel | input | 2 | 0 or 3 none, 1 signed clamp, 2 unsigned clamp |
| rec_en | input | 1 | Produce the condition field |
| result | output | 64 | Lane result, zero above the lane |
| carry_out | output | 1 | Carry out of the lane's top bit |
| overflow | output | 1 | Exact sum outside target range |
| cond | output | 4 | {LT, GT, EQ, SO} |

## Verification
The adder is exercised at every lane width with the largest positive and negative values, sums that just overflow, operands carrying garbage above the lane, and carry-in offered both enabled and disabled. These cases separate a carry or clamp taken at the lane boundary from one taken at bit 64. They also show whether high operand bits leak into the lane. A sweep over all width, sign and clamp combinations with pseudo-random operands distinguishes the signed-operand/unsigned-clamp case, which must floor at zero, from plain unsigned wrapping. Two consecutive operations, one overflowing and one not, show whether SO is sticky.

// File: rtl/ewadd_pkg.sv
package ewadd_pkg;

  typedef enum logic [1:0] {
    EW_8    = 2'd0,
    EW_16   = 2'd1,
    EW_32   = 2'd2,
    EW_FULL = 2'd3
  } ew_e;

  typedef enum logic [1:0] {
    SAT_OFF  = 2'd0,
    SAT_SGN  = 2'd1,
    SAT_UNS  = 2'd2,
    SAT_OFF2 = 2'd3
  } sat_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;

endpackage

// File: rtl/ewadd_core.sv
module ewadd_core #(
  parameter int DATA_W = 64,
  localparam int XW = DATA_W + 2,
  localparam int LW = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              carry_in,
  input  logic              use_carry,
  input  logic [1:0]        ew,
  input  logic              op_signed,
  output logic [XW-1:0]     exact,
  output logic              carry_out,
  output logic [DATA_W-1:0] lane_mask,
  output logic [LW-1:0]     lane_w
);

  // lane width: DATA_W/8, /4, /2, /1
  function automatic logic [LW-1:0] lane_bits(input logic [1:0] e);
    logic [LW:0] full;
    full = (LW+1)'(DATA_W);
    return LW'(full >> (2'd3 - e));
  endfunction

  function automatic logic [DATA_W-1:0] make_mask(input logic [LW-1:0] w);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i < int'(w));
    return m;
  endfunction

  // extend a lane value to XW bits, by sign or by zero
  function automatic logic [XW-1:0] widen(input logic [DATA_W-1:0] v,
                                          input logic [DATA_W-1:0] m,
                                          input logic [LW-1:0] w,
                                          input logic sgn);
    logic [XW-1:0] r;
    logic          fill;
    fill = sgn & v[w - LW'(1)];
    r = {2'b00, v & m};
    for (int i = 0; i < XW; i++)
      if (i >= int'(w)) r[i] = fill;
    return r;
  endfunction

  logic              cin_eff;
  logic [DATA_W:0]   usum;
  logic [XW-1:0]     a_x, b_x;

  always_comb begin
    lane_w    = lane_bits(ew);
    lane_mask = make_mask(lane_w);
    cin_eff   = carry_in & use_carry;
    usum      = {1'b0, op_lane(a)} + {1'b0, op_lane(b)} + (DATA_W+1)'(cin_eff);
    carry_out = usum[lane_w];
    a_x       = widen(a, lane_mask, lane_w, op_signed);
    b_x       = widen(b, lane_mask, lane_w, op_signed);
    exact     = a_x + b_x + XW'(cin_eff);
  end

  function automatic logic [DATA_W-1:0] op_lane(input logic [DATA_W-1:0] v);
    return v & lane_mask;
  endfunction

endmodule

// File: rtl/ewadd_sat.sv
module ewadd_sat
  import ewadd_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int XW = DATA_W + 2,
  localparam int LW = $clog2(DATA_W) + 1
) (
  input  logic [XW-1:0]     exact,
  input  logic [DATA_W-1:0] lane_mask,
  input  logic [LW-1:0]     lane_w,
  input  logic [1:0]        sat_sel,
  input  logic              op_signed,
  output logic [DATA_W-1:0] res,
  output logic              ovf
);

  // bounds of the target range as XW-bit signed values
  function automatic logic [XW-1:0] upper_bound(input logic tsg, input logic [LW-1:0] w);
    logic [XW-1:0] one;
    one = XW'(1);
    return tsg ? (one << (w - LW'(1))) - one : (one << w) - one;
  endfunction

  function automatic logic [XW-1:0] lower_bound(input logic tsg, input logic [LW-1:0] w);
    logic [XW-1:0] one;
    one = XW'(1);
    return tsg ? -(one << (w - LW'(1))) : '0;
  endfunction

  sat_e          mode;
  logic          tgt_signed;
  logic          clamp_en;
  logic [XW-1:0] hi, lo, fin;
  logic          above, below;

  always_comb begin
    mode       = sat_e'(sat_sel);
    tgt_signed = (mode == SAT_SGN) || ((mode != SAT_UNS) && op_signed);
    clamp_en   = (mode == SAT_SGN) || (mode == SAT_UNS);
    hi         = upper_bound(tgt_signed, lane_w);
    lo         = lower_bound(tgt_signed, lane_w);
    above      = $signed(exact) > $signed(hi);
    below      = $signed(exact) < $signed(lo);
    ovf        = above | below;
    fin        = exact;
    if (clamp_en && above) fin = hi;
    if (clamp_en && below) fin = lo;
    res        = fin[DATA_W-1:0] & lane_mask;
  end

endmodule

// File: rtl/ewadd_flags.sv
module ewadd_flags
  import ewadd_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int LW = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] res,
  input  logic [LW-1:0]     lane_w,
  input  logic              ovf,
  input  logic              rec_en,
  output logic [3:0]        cond
);

  cond_t c;
  logic  neg, zero;

  always_comb begin
    neg  = res[lane_w - LW'(1)];
    zero = (res == '0);
    c.lt = neg;
    c.gt = !neg && !zero;
    c.eq = zero;
    c.so = ovf;
    cond = rec_en ? c : 4'b0000;
  end

endmodule

// File: rtl/ew_sat_adder.sv
module ew_sat_adder
  import ewadd_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter bit REG_OUT = 1'b1,
  localparam int XW = DATA_W + 2,
  localparam int LW = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       op_a,
  input  logic [63:0]       op_b,
  input  logic              carry_in,
  input  logic              use_carry,
  input  logic [1:0]        ew_sel,
  input  logic              op_signed,
  input  logic [1:0]        sat_sel,
  input  logic              rec_en,
  output logic [63:0]       result,
  output logic              carry_out,
  output logic              overflow,
  output logic [3:0]        cond
);

  logic [XW-1:0]     exact;
  logic              c_co;
  logic [DATA_W-1:0] lane_mask;
  logic [LW-1:0]     lane_w;
  logic [DATA_W-1:0] c_res;
  logic              c_ovf;
  logic [3:0]        c_cond;

  ewadd_core #(.DATA_W(DATA_W)) u_core (
    .a(op_a[DATA_W-1:0]), .b(op_b[DATA_W-1:0]), .carry_in(carry_in),
    .use_carry(use_carry), .ew(ew_sel), .op_signed(op_signed),
    .exact(exact), .carry_out(c_co), .lane_mask(lane_mask), .lane_w(lane_w)
  );

  ewadd_sat #(.DATA_W(DATA_W)) u_sat (
    .exact(exact), .lane_mask(lane_mask), .lane_w(lane_w),
    .sat_sel(sat_sel), .op_signed(op_signed), .res(c_res), .ovf(c_ovf)
  );

  ewadd_flags #(.DATA_W(DATA_W)) u_flags (
    .res(c_res), .lane_w(lane_w), .ovf(c_ovf), .rec_en(rec_en), .cond(c_cond)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          result    <= '0;
          carry_out <= 1'b0;
          overflow  <= 1'b0;
          cond      <= '0;
        end else begin
          result    <= 64'(c_res);
          carry_out <= c_co;
          overflow  <= c_ovf;
          cond      <= c_cond;
        end
      end
    end else begin : g_comb
      always_comb begin
        result    = 64'(c_res);
        carry_out = c_co;
        overflow  = c_ovf;
        cond      = c_cond;
      end
    end
  endgenerate

  // R1: nothing of the sum leaks above the lane
  p_upper_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (c_res & ~lane_mask) == '0);

  // R5: an in-range sum passes the clamp stage untouched
  p_inrange_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !c_ovf |-> c_res == (exact[DATA_W-1:0] & lane_mask));

  // R7: unsigned clamp floors a negative exact sum at zero
  p_uns_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_sel == SAT_UNS && exact[XW-1]) |-> c_res == '0);

  // R6: signed clamp of a positive overflow never yields a negative lane
  p_sgn_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_sel == SAT_SGN && c_ovf && !exact[XW-1]) |-> !c_res[lane_w - LW'(1)]);

  // R8: one relation to zero is reported
  p_one_rel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_en |-> $onehot(c_cond[3:1]));

  // R9: SO follows this operation's overflow; field silent without record
  p_so_now_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rec_en |-> c_cond[0] == c_ovf);
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_en |-> c_cond == 4'b0000);

endmodule

// File: tb/ew_sat_adder_test.sv
module ew_sat_adder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic        carry_in = 1'b0, use_carry = 1'b0;
  logic [1:0]  ew_sel = '0;
  logic        op_signed = 1'b0;
  logic [1:0]  sat_sel = '0;
  logic        rec_en = 1'b0;
  logic [63:0] result;
  logic        carry_out, overflow;
  logic [3:0]  cond;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  ew_sat_adder uut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .use_carry(use_carry), .ew_sel(ew_sel), .op_signed(op_signed),
    .sat_sel(sat_sel), .rec_en(rec_en), .result(result),
    .carry_out(carry_out), .overflow(overflow), .cond(cond)
  );

  typedef struct {
    logic [63:0] res;
    logic        co;
    logic        ov;
    logic [3:0]  cf;
    string       tag;
  } item_t;

  item_t sb[$];

  // reference: 128-bit arithmetic, independent of the design's structure
  function automatic item_t model(logic [63:0] a, logic [63:0] b, logic cin, logic uc,
                                  logic [1:0] ew, logic sg, logic [1:0] sat, logic rec);
    item_t it;
    int w;
    logic [127:0] m, am, bm, us;
    logic signed [127:0] ea, eb, ex, hi, lo, fin;
    logic c, tsg, neg;
    w  = 8 << ew;
    m  = (128'd1 << w) - 128'd1;
    am = {64'd0, a} & m;
    bm = {64'd0, b} & m;
    c  = uc & cin;
    if (sg) begin
      ea = $signed(am << (128 - w)) >>> (128 - w);
      eb = $signed(bm << (128 - w)) >>> (128 - w);
    end else begin
      ea = $signed(am);
      eb = $signed(bm);
    end
    ex  = ea + eb + $signed({127'd0, c});
    us  = am + bm + {127'd0, c};
    tsg = (sat == 2'd1) || (sat != 2'd2 && sg);
    if (tsg) begin
      hi = (128'sd1 <<< (w - 1)) - 128'sd1;
      lo = -(128'sd1 <<< (w - 1));
    end else begin
      hi = (128'sd1 <<< w) - 128'sd1;
      lo = 128'sd0;
    end
    fin = ex;
    if (sat == 2'd1 || sat == 2'd2) begin
      if (ex > hi) fin = hi;
      if (ex < lo) fin = lo;
    end
    it.res = fin[63:0] & m[63:0];
    it.co  = us[w];
    it.ov  = (ex > hi) || (ex < lo);
    neg    = it.res[w-1];
    it.cf  = rec ? {neg, !neg && it.res != 64'd0, it.res == 64'd0, it.ov} : 4'b0000;
    return it;
  endfunction

  task automatic drive(logic [63:0] a, logic [63:0] b, logic cin, logic uc,
                       logic [1:0] ew, logic sg, logic [1:0] sat, logic rec, string tag);
    item_t it;
    @(negedge clk);
    op_a = a; op_b = b; carry_in = cin; use_carry = uc;
    ew_sel = ew; op_signed = sg; sat_sel = sat; rec_en = rec;
    it = model(a, b, cin, uc, ew, sg, sat, rec);
    it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: one registered stage, so each item is visible after the next edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() != 0) begin
        item_t e;
        e = sb.pop_front();
        total++;
        if (result !== e.res || carry_out !== e.co || overflow !== e.ov || cond !== e.cf) begin
          bad++;
          $display("FAIL %s: got res=%h co=%b ov=%b cond=%b, expected res=%h co=%b ov=%b cond=%b",
                   e.tag, result, carry_out, overflow, cond, e.res, e.co, e.ov, e.cf);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: got hang, expected completion");
    finish_run();
  end

  initial begin
    // R10: outputs held at zero in reset
    op_a = 64'hFFFF; op_b = 64'h1; rec_en = 1'b1;
    repeat (3) @(negedge clk);
    total++;
    if (result !== 64'd0 || carry_out !== 1'b0 || overflow !== 1'b0 || cond !== 4'd0) begin
      bad++;
      $display("FAIL R10: got res=%h co=%b ov=%b cond=%b, expected all zero",
               result, carry_out, overflow, cond);
    end
    rst_n = 1'b1;

    // R1: 8-bit wrap, 0xF0 + 0x20 -> 0x10
    drive(64'hF0, 64'h20, 0, 0, 2'd0, 0, 2'd0, 0, "R1 wrap8");
    drive(64'hFFFF, 64'h0001, 0, 0, 2'd1, 0, 2'd0, 0, "R1 wrap16");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 2'd3, 0, 2'd0, 0, "R1 wrap64");
    // R2: garbage above the lane
    drive(64'hDEAD_BEEF_0000_0005, 64'h1234_5678_9ABC_0003, 0, 0, 2'd1, 1, 2'd1, 1, "R2 high bits");
    drive(64'hFFFF_FF00_0000_007F, 64'hAAAA_AAAA_AAAA_AA00, 0, 0, 2'd0, 1, 2'd1, 1, "R2 high bits sat");
    // R3: carry offered but disabled, then enabled
    drive(64'h10, 64'h10, 1, 0, 2'd0, 0, 2'd0, 1, "R3 carry ignored");
    drive(64'h10, 64'h10, 1, 1, 2'd0, 0, 2'd0, 1, "R3 carry used");
    // R4: carry-out at lane boundary
    drive(64'hFFFF_FFFF, 64'd1, 0, 0, 2'd2, 0, 2'd0, 0, "R4 carry32");
    drive(64'hFF, 64'h00, 1, 1, 2'd0, 0, 2'd0, 0, "R4 carry8 from cin");
    drive(64'h1_0000_00FF, 64'h1, 0, 0, 2'd0, 0, 2'd0, 0, "R4 bit above lane");
    // R5: signed overflow without clamp
    drive(64'h7F, 64'h01, 0, 0, 2'd0, 1, 2'd0, 1, "R5 signed ovf");
    drive(64'h7F, 64'h01, 0, 0, 2'd0, 0, 2'd0, 1, "R5 unsigned no ovf");
    // R6: signed clamp both ends
    drive(64'h7F, 64'h01, 0, 0, 2'd0, 1, 2'd1, 1, "R6 clamp max");
    drive(64'h80, 64'hFF, 0, 0, 2'd0, 1, 2'd1, 1, "R6 clamp min");
    drive(64'h7FFF_FFFF_FFFF_FFFF, 64'd5, 0, 0, 2'd3, 1, 2'd1, 1, "R6 clamp64");
    // R7: unsigned clamp
    drive(64'hFF, 64'h01, 0, 0, 2'd0, 0, 2'd2, 1, "R7 clamp top");
    drive(64'h80, 64'h00, 0, 0, 2'd0, 1, 2'd2, 1, "R7 negative floors");
    drive(64'hFFFF_FFFE, 64'hFFFF_FFFF, 0, 0, 2'd2, 1, 2'd2, 1, "R7 neg32 floors");
    // R8: zero, negative, positive
    drive(64'h05, 64'hFB, 0, 0, 2'd0, 1, 2'd0, 1, "R8 eq");
    drive(64'hF0, 64'h01, 0, 0, 2'd0, 1, 2'd0, 1, "R8 lt");
    drive(64'h01, 64'h01, 0, 0, 2'd1, 1, 2'd0, 1, "R8 gt");
    // R9: no stickiness, quiet without record
    drive(64'h7FFF, 64'h7FFF, 0, 0, 2'd1, 1, 2'd0, 1, "R9 ovf op");
    drive(64'h0001, 64'h0001, 0, 0, 2'd1, 1, 2'd0, 1, "R9 next op clean");
    drive(64'h7FFF, 64'h7FFF, 0, 0, 2'd1, 1, 2'd0, 0, "R9 no record");
    // sweep every combination, pseudo-random operands
    for (int e = 0; e < 4; e++)
      for (int s = 0; s < 2; s++)
        for (int t = 0; t < 4; t++)
          for (int u = 0; u < 2; u++)
            for (int k = 0; k < 4; k++)
              drive({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), 1'(u),
                    2'(e), 1'(s), 2'(t), 1'(k[0]), "R5 sweep");
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule